// File: doc/BRIEF.md
# Condition Bit to Register Setter

This block turns a single bit of a 32-bit condition register into a full-width general-purpose register result. The condition register is split into eight 4-bit fields. A 5-bit index names one bit of it: the upper three index bits choose the field and the lower two choose the bit inside that field. The tested bit becomes a result of 0 or 1. Two independent controls change that result. The reverse control inverts the sense that is tested. The negate control widens a 1 into a value with every bit set.

An execution pipeline presents one operation per cycle, together with a feature-level enable. One cycle later the block returns a 64-bit value, a write enable for the destination register and an illegal flag. The illegal flag replaces the write when the feature level is not enabled. The register file and the instruction decoder sit outside this block.

Top module: `cond_bit_setter`

## Requirements
- R1: Each cycle in which `op_valid` is high produces `res_valid` high on the following cycle. A cycle with `op_valid` low produces `res_valid`, `res_wen` and `res_illegal` low and `res_value` zero on the following cycle.
- R2: `op_idx[4:2]` selects the field. Field 0 is the most significant nibble `cond_reg[31:28]` and field 7 is `cond_reg[3:0]`.
- R3: Inside the field, `op_idx[1:0]` selects the bit using the mask 4'b1000 shifted right by that value. Taken together with R2, the tested bit is `cond_reg[31 - op_idx]`.
- R4: With `op_neg`=0 and `op_rev`=0, the result is 1 when the tested bit is set and 0 when it is clear.
- R5: With `op_rev`=1 and `op_neg`=0, the result is 1 when the tested bit is clear and 0 when it is set.
- R6: With `op_neg`=1 and `op_rev`=0, the result is all ones (64'hFFFF_FFFF_FFFF_FFFF) when the tested bit is set and 0 when it is clear.
- R7: With `op_neg`=1 and `op_rev`=1, the result is all ones when the tested bit is clear and 0 when it is set.
- R8: A valid operation with `feat_en`=0 gives `res_illegal`=1, `res_wen`=0 and `res_value`=0, whatever the condition register, index and controls are.
- R9: A valid operation with `feat_en`=1 gives `res_wen`=1 and `res_illegal`=0. `res_wen` and `res_illegal` are never high together.
- R10: While `rst` is high, and on the cycle after it is released, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_idx | input | 5 | Condition bit index (field in [4:2], bit in [1:0]) |
| op_neg | input | 1 | Negate: widen a 1 result to all ones |
| op_rev | input | 1 | Reverse: test for a clear bit |
| feat_en | input | 1 | Feature level enabled; when low the operation is illegal |
| cond_reg | input | 32 | Condition register, eight 4-bit fields |
| res_valid | output | 1 | Result present, one cycle after op_valid |
| res_wen | output | 1 | Write the result to the destination register |
| res_illegal | output | 1 | Operation rejected as illegal |
| res_value | output | 64 | Result value |

## Verification
The assertions sample `cond_reg`, `op_idx` and the controls in the same cycle as `op_valid`. They assume these inputs are known (not X) in every cycle after reset, because the value checks index the condition register with `op_idx` through `$past`. The bench drives every input to a defined value before reset is released. It changes inputs only at the falling edge, so each operation is captured whole at the next rising edge. It sweeps all 32 index values under each of the four control variants, walks a single set bit across the condition register, and repeats operations with the feature disabled using non-zero register contents.

// File: rtl/cbset_pkg.sv
package cbset_pkg;

    localparam int CR_BITS    = 32;
    localparam int FIELD_BITS = 4;
    localparam int NUM_FIELDS = CR_BITS / FIELD_BITS;
    localparam int IDX_BITS   = $clog2(CR_BITS);
    localparam int FSEL_BITS  = $clog2(NUM_FIELDS);
    localparam int BSEL_BITS  = $clog2(FIELD_BITS);
    localparam int RES_BITS   = 64;

    typedef enum logic [1:0] {
        VAR_PLAIN  = 2'b00,
        VAR_REV    = 2'b01,
        VAR_NEG    = 2'b10,
        VAR_NEGREV = 2'b11
    } cbs_variant_e;

    typedef struct packed {
        logic                neg;
        logic                rev;
        logic [IDX_BITS-1:0] idx;
    } cbs_op_t;

    typedef struct packed {
        logic                valid;
        logic                wen;
        logic                illegal;
        logic [RES_BITS-1:0] value;
    } cbs_result_t;

    function automatic logic [FSEL_BITS-1:0] field_of(input logic [IDX_BITS-1:0] idx);
        return idx[IDX_BITS-1 -: FSEL_BITS];
    endfunction

    function automatic logic [BSEL_BITS-1:0] lane_of(input logic [IDX_BITS-1:0] idx);
        return idx[BSEL_BITS-1:0];
    endfunction

    function automatic cbs_variant_e variant_of(input cbs_op_t op);
        return cbs_variant_e'({op.neg, op.rev});
    endfunction

endpackage

// File: rtl/cbs_field_pick.sv
module cbs_field_pick #(
    parameter int CR_W    = cbset_pkg::CR_BITS,
    parameter int FIELD_W = cbset_pkg::FIELD_BITS,
    localparam int NF     = CR_W / FIELD_W,
    localparam int FSEL_W = $clog2(NF)
) (
    input  logic [CR_W-1:0]    cr,
    input  logic [FSEL_W-1:0]  fsel,
    output logic [FIELD_W-1:0] field
);
    logic [FIELD_W-1:0] fields [NF];

    // Field 0 is the most significant slice of the register.
    for (genvar f = 0; f < NF; f++) begin : g_field
        assign fields[f] = cr[CR_W-1-f*FIELD_W -: FIELD_W];
    end

    assign field = fields[fsel];
endmodule

// File: rtl/cbs_bit_test.sv
module cbs_bit_test #(
    parameter int FIELD_W = cbset_pkg::FIELD_BITS,
    localparam int BSEL_W = $clog2(FIELD_W)
) (
    input  logic [FIELD_W-1:0] field,
    input  logic [BSEL_W-1:0]  bsel,
    output logic               hit
);
    localparam logic [FIELD_W-1:0] TOP_ONE = {1'b1, {(FIELD_W-1){1'b0}}};

    logic [FIELD_W-1:0] mask;

    always_comb begin
        mask = TOP_ONE >> bsel;
        hit  = |(field & mask);
    end
endmodule

// File: rtl/cbs_result_form.sv
module cbs_result_form
    import cbset_pkg::*;
#(
    parameter int RES_W = cbset_pkg::RES_BITS
) (
    input  logic         hit,
    input  cbs_variant_e variant,
    output logic [RES_W-1:0] value
);
    logic truth;

    always_comb begin
        truth = hit;
        value = '0;
        unique case (variant)
            VAR_PLAIN: begin
                truth = hit;
                value = {{(RES_W-1){1'b0}}, truth};
            end
            VAR_REV: begin
                truth = ~hit;
                value = {{(RES_W-1){1'b0}}, truth};
            end
            VAR_NEG: begin
                truth = hit;
                value = {RES_W{truth}};
            end
            VAR_NEGREV: begin
                truth = ~hit;
                value = {RES_W{truth}};
            end
            default: value = '0;
        endcase
    end
endmodule

// File: rtl/cond_bit_setter.sv
module cond_bit_setter
    import cbset_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [IDX_BITS-1:0] op_idx,
    input  logic                op_neg,
    input  logic                op_rev,
    input  logic                feat_en,
    input  logic [CR_BITS-1:0]  cond_reg,
    output logic                res_valid,
    output logic                res_wen,
    output logic                res_illegal,
    output logic [RES_BITS-1:0] res_value
);
    cbs_op_t            op;
    logic [FIELD_BITS-1:0] field;
    logic               hit;
    logic [RES_BITS-1:0] formed;
    cbs_result_t        next_res;
    cbs_result_t        res_q;

    assign op = '{neg: op_neg, rev: op_rev, idx: op_idx};

    cbs_field_pick #(.CR_W(CR_BITS), .FIELD_W(FIELD_BITS)) u_pick (
        .cr    (cond_reg),
        .fsel  (field_of(op.idx)),
        .field (field)
    );

    cbs_bit_test #(.FIELD_W(FIELD_BITS)) u_test (
        .field (field),
        .bsel  (lane_of(op.idx)),
        .hit   (hit)
    );

    cbs_result_form #(.RES_W(RES_BITS)) u_form (
        .hit     (hit),
        .variant (variant_of(op)),
        .value   (formed)
    );

    always_comb begin
        next_res         = '0;
        next_res.valid   = op_valid;
        next_res.wen     = op_valid & feat_en;
        next_res.illegal = op_valid & ~feat_en;
        next_res.value   = (op_valid & feat_en) ? formed : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= next_res;
    end

    assign res_valid   = res_q.valid;
    assign res_wen     = res_q.wen;
    assign res_illegal = res_q.illegal;
    assign res_value   = res_q.value;
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker
    import cbset_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                op_valid,
    input logic [IDX_BITS-1:0] op_idx,
    input logic                op_neg,
    input logic                op_rev,
    input logic                feat_en,
    input logic [CR_BITS-1:0]  cond_reg,
    input logic                res_valid,
    input logic                res_wen,
    input logic                res_illegal,
    input logic [RES_BITS-1:0] res_value
);
    localparam logic [RES_BITS-1:0] ONE  = {{(RES_BITS-1){1'b0}}, 1'b1};
    localparam logic [RES_BITS-1:0] ONES = {RES_BITS{1'b1}};

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && !res_wen && !res_illegal && res_value == '0));

    // Direct bit indexing, independent of the field/mask path.
    assert_plain_bit_R3_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && feat_en && !op_neg && !op_rev) |=>
        (res_value == ($past(cond_reg[CR_BITS-1-int'(op_idx)]) ? ONE : '0)));
    assert_rev_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && feat_en && !op_neg && op_rev) |=>
        (res_value == ($past(cond_reg[CR_BITS-1-int'(op_idx)]) ? '0 : ONE)));
    assert_neg_bit_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && feat_en && op_neg && !op_rev) |=>
        (res_value == ($past(cond_reg[CR_BITS-1-int'(op_idx)]) ? ONES : '0)));
    assert_negrev_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && feat_en && op_neg && op_rev) |=>
        (res_value == ($past(cond_reg[CR_BITS-1-int'(op_idx)]) ? '0 : ONES)));
    assert_disabled_illegal_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !feat_en) |=> (res_illegal && !res_wen && res_value == '0));
    assert_enabled_writes_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && feat_en) |=> (res_wen && !res_illegal));
    assert_wen_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(res_wen && res_illegal));
    assert_reset_clear_R10: assert property (@(posedge clk)
        $past(rst) |-> (!res_valid && !res_wen && !res_illegal && res_value == '0));
endmodule

bind cond_bit_setter cbs_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .op_idx      (op_idx),
    .op_neg      (op_neg),
    .op_rev      (op_rev),
    .feat_en     (feat_en),
    .cond_reg    (cond_reg),
    .res_valid   (res_valid),
    .res_wen     (res_wen),
    .res_illegal (res_illegal),
    .res_value   (res_value)
);

// File: tb/cond_bit_setter_test.sv
`timescale 1ns/1ps
module cond_bit_setter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [4:0]  op_idx = '0;
    logic        op_neg = 1'b0;
    logic        op_rev = 1'b0;
    logic        feat_en = 1'b0;
    logic [31:0] cond_reg = '0;
    logic        res_valid, res_wen, res_illegal;
    logic [63:0] res_value;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cond_bit_setter uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_idx(op_idx),
        .op_neg(op_neg), .op_rev(op_rev), .feat_en(feat_en), .cond_reg(cond_reg),
        .res_valid(res_valid), .res_wen(res_wen), .res_illegal(res_illegal),
        .res_value(res_value)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [31:0] cr, input logic [4:0] idx,
                                          input logic neg, input logic rev);
        logic b;
        b = cr[31 - idx] ^ rev;
        if (neg) return b ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0;
        return {63'h0, b};
    endfunction

    // Present one operation at a falling edge, check at the next falling edge.
    task automatic run_op(input string req, input logic [31:0] cr, input logic [4:0] idx,
                          input logic neg, input logic rev, input logic en);
        op_valid = 1'b1; cond_reg = cr; op_idx = idx;
        op_neg = neg; op_rev = rev; feat_en = en;
        @(negedge clk);
        check({req, " valid"}, {63'h0, res_valid}, 64'h1);
        if (en) begin
            check({req, " R9 wen"}, {63'h0, res_wen}, 64'h1);
            check({req, " R9 illegal"}, {63'h0, res_illegal}, 64'h0);
            check({req, " value"}, res_value, model(cr, idx, neg, rev));
        end else begin
            check({req, " R8 illegal"}, {63'h0, res_illegal}, 64'h1);
            check({req, " R8 wen"}, {63'h0, res_wen}, 64'h0);
            check({req, " R8 value"}, res_value, 64'h0);
        end
    endtask

    task automatic test_reset();
        check("R10 valid", {63'h0, res_valid}, 64'h0);
        check("R10 wen", {63'h0, res_wen}, 64'h0);
        check("R10 illegal", {63'h0, res_illegal}, 64'h0);
        check("R10 value", res_value, 64'h0);
    endtask

    task automatic test_variant(input string req, input logic neg, input logic rev);
        for (int i = 0; i < 32; i++) begin
            run_op(req, 32'hA5C3_96F0, 5'(i), neg, rev, 1'b1);
            run_op(req, 32'h5A3C_690F, 5'(i), neg, rev, 1'b1);
        end
    endtask

    // R2/R3: single set bit walked across the register; only one index hits.
    task automatic test_walk();
        for (int p = 0; p < 32; p++) begin
            for (int i = 0; i < 32; i++) begin
                run_op("R2 R3 walk", 32'h1 << p, 5'(i), 1'b0, 1'b0, 1'b1);
            end
        end
        // Field 0 bit 0 is the register's top bit.
        run_op("R2 top", 32'h8000_0000, 5'd0, 1'b0, 1'b0, 1'b1);
        check("R2 top direct", res_value, 64'h1);
        run_op("R3 lane", 32'h0100_0000, 5'd7, 1'b0, 1'b0, 1'b1);
        check("R3 lane direct", res_value, 64'h1);
    endtask

    task automatic test_disabled();
        for (int i = 0; i < 32; i += 5) begin
            run_op("R8 disabled", 32'hFFFF_FFFF, 5'(i), i[0], i[1], 1'b0);
            run_op("R8 disabled", 32'h0000_0000, 5'(i), 1'b1, 1'b1, 1'b0);
        end
    endtask

    task automatic test_idle();
        run_op("R1 pre", 32'hFFFF_FFFF, 5'd3, 1'b1, 1'b0, 1'b1);
        op_valid = 1'b0;
        @(negedge clk);
        check("R1 idle valid", {63'h0, res_valid}, 64'h0);
        check("R1 idle wen", {63'h0, res_wen}, 64'h0);
        check("R1 idle illegal", {63'h0, res_illegal}, 64'h0);
        check("R1 idle value", res_value, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_variant("R4 plain", 1'b0, 1'b0);
        test_variant("R5 rev", 1'b0, 1'b1);
        test_variant("R6 neg", 1'b1, 1'b0);
        test_variant("R7 negrev", 1'b1, 1'b1);
        test_walk();
        test_disabled();
        test_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule